// File: doc/BRIEF.md
# Boundary-Synchronous Square-Wave Frequency Generator

This block produces a square wave whose period is a whole number of system clock cycles. The host supplies that count directly as a period request with a write strobe. At 25 MHz, a count of 500 gives 50 kHz, 501 gives the next 100 Hz step down, and 25000 gives 1 kHz. The block does not convert a measured voltage into a count; the count arrives ready to use.

A request is not applied straight away. It is held in a shadow register and moved into the running period setting only when the current period ends. The output therefore never shows a truncated or lengthened partial cycle, however often or however late in a period the host writes.

If no new request arrives, the last prepared value keeps being used for every following period. A one-clock end-of-period flag marks the last clock of each period, which is the point where the shadow value is taken over. Requests below 2 are raised to 2.

Top module: `glitchfree_freq_gen`

## Requirements
- R1: While reset is asserted, `wave_out` is 1 and `period_end` is 0. The first period after reset release lasts RESET_PERIOD clocks.
- R2: Every period lasts exactly N clocks, where N is the running period setting. `period_end` is 1 on the last clock of each period and only on that clock.
- R3: Each period begins with `wave_out` high for floor(N/2) clocks, then low for the remaining N - floor(N/2) clocks.
- R4: A request written part-way through a period leaves that period's length and phases unchanged. It governs the next period.
- R5: With no writes, the running setting is reused unchanged for every following period.
- R6: When several requests are written within one period, only the last one takes effect at the boundary.
- R7: A request written on the same clock that `period_end` is 1 governs the period that starts on the next clock.
- R8: A requested value of 0 or 1 is treated as 2, which gives 1 clock high and 1 clock low.
- R9: Period counts up to 2^CNT_W - 1 are supported, with a default of 16 bits. A 25000-clock request gives a 25000-clock period, high for 12500 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_in | input | CNT_W | Requested period in clock cycles |
| period_wr | input | 1 | Write strobe for `period_in` |
| wave_out | output | 1 | Square-wave output |
| period_end | output | 1 | High on the last clock of each period |

## Verification
The bench goes after the following cases, each chosen because a specific mistake would show up in it:
- **Mid-period write.** A design that loaded the running setting immediately would produce a period whose measured length matches neither the old nor the new count.
- **Write on the boundary clock.** A design that ignored such a write would delay the change by one full period, and the bench would see the old length.
- **Two writes in one period.** A design that kept the first write instead of the last would show the wrong final length.
- **Odd counts.** An odd count exposes a high/low split that rounds the wrong way.
- **Requests of 0 and 1.** Without the clamp these would stall the counter or produce an empty high phase.
- **A 25000-clock period.** This shows whether the counter is wide enough.

// File: rtl/glitchfree_freq_gen.sv
`timescale 1ns/1ps
module glitchfree_freq_gen #(
  parameter int CNT_W        = 16,
  parameter int RESET_PERIOD = 500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_in,
  input  logic             period_wr,
  output logic             wave_out,
  output logic             period_end
);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
  localparam logic [CNT_W-1:0] MIN_P = CNT_W'(2);
  localparam logic [CNT_W-1:0] RST_P = CNT_W'(RESET_PERIOD);

  logic [CNT_W-1:0] cnt_q, active_q, shadow_q;
  logic [CNT_W-1:0] req_clamped, next_active, next_cnt;
  logic             wave_q;

  assign req_clamped = (period_in < MIN_P) ? MIN_P : period_in;
  assign period_end  = (cnt_q == active_q - ONE);
  assign next_cnt    = period_end ? '0 : cnt_q + ONE;
  assign next_active = !period_end ? active_q
                     : (period_wr ? req_clamped : shadow_q);
  assign wave_out    = wave_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      active_q <= RST_P;
      shadow_q <= RST_P;
      wave_q   <= ((RST_P >> 1) != '0);
    end else begin
      cnt_q    <= next_cnt;
      active_q <= next_active;
      if (period_wr) shadow_q <= req_clamped;
      wave_q   <= (next_cnt < (next_active >> 1));
    end
  end
endmodule

module glitchfree_freq_gen_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wave_out,
  input logic             period_end,
  input logic [CNT_W-1:0] active_q
);
  a_r2_end_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> !period_end);
  a_r3_low_on_last_clock: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |-> !wave_out);
  a_r3_high_after_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> wave_out);
  a_r3_rise_only_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wave_out) |-> $past(period_end));
  a_r4_setting_held_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(period_end) |-> $stable(active_q));
  a_r8_setting_at_least_two: assert property (@(posedge clk) disable iff (!rst_n)
    active_q >= CNT_W'(2));
endmodule

bind glitchfree_freq_gen glitchfree_freq_gen_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wave_out(wave_out),
  .period_end(period_end), .active_q(active_q)
);

// File: tb/glitchfree_freq_gen_tb_top.sv
`timescale 1ns/1ps
module glitchfree_freq_gen_tb_top;
  localparam int CNT_W = 16;
  localparam int RST_P = 10;
  localparam int NV    = 9;
  localparam int VP [NV] = '{6, 7, 2, 3, 0, 1, 500, 501, 25000};
  localparam int VH [NV] = '{3, 3, 1, 1, 1, 1, 250, 250, 12500};
  localparam int VL [NV] = '{3, 4, 1, 2, 1, 1, 250, 251, 12500};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CNT_W-1:0] period_in = '0;
  logic period_wr = 1'b0;
  logic wave_out, period_end;
  int n_checks = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  glitchfree_freq_gen #(.CNT_W(CNT_W), .RESET_PERIOD(RST_P)) dut_i (
    .clk(clk), .rst_n(rst_n), .period_in(period_in), .period_wr(period_wr),
    .wave_out(wave_out), .period_end(period_end));

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(output int len, output int hi);
    bit done;
    len = 0; hi = 0; done = 1'b0;
    while (!done) begin
      if (wave_out) hi++;
      len++;
      done = period_end;
      @(negedge clk);
    end
  endtask

  task automatic wait_boundary();
    while (!period_end) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic write_req(int v);
    period_in = CNT_W'(v);
    period_wr = 1'b1;
    @(negedge clk);
    period_wr = 1'b0;
  endtask

  task automatic run_tests();
    int len, hi;
    repeat (3) @(negedge clk);
    check("R1 wave_out in reset", int'(wave_out), 1);
    check("R1 period_end in reset", int'(period_end), 0);
    rst_n = 1'b1;
    measure(len, hi);
    check("R1 first period length", len, RST_P);
    check("R3 first period high", hi, RST_P / 2);
    for (int k = 0; k < 3; k++) begin
      measure(len, hi);
      check("R5 reused period length", len, RST_P);
      check("R2 reused period high", hi, RST_P / 2);
    end
    // R4: write during the fourth clock of a 10-clock period
    repeat (3) @(negedge clk);
    write_req(4);
    measure(len, hi);
    check("R4 current period unchanged", len + 4, RST_P);
    measure(len, hi);
    check("R4 next period takes request", len, 4);
    check("R3 next period high", hi, 2);
    // R6: two writes inside one period
    write_req(7);
    write_req(9);
    wait_boundary();
    measure(len, hi);
    check("R6 last write wins length", len, 9);
    check("R6 last write wins high", hi, 4);
    // R7: write on the boundary clock
    while (!period_end) @(negedge clk);
    write_req(6);
    measure(len, hi);
    check("R7 boundary write applied", len, 6);
    check("R7 boundary write high", hi, 3);
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = (VP[i] < 2) ? "R8" : ((VP[i] >= 25000) ? "R9" : "R2");
      write_req(VP[i]);
      wait_boundary();
      measure(len, hi);
      check({tag, " table period length"}, len, VH[i] + VL[i]);
      check({(VP[i] < 2) ? "R8" : "R3", " table high phase"}, hi, VH[i]);
    end
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule